// File: doc/BRIEF.md
# Shared-Bus Register File with Address Selector

This block is the register storage of a microcoded processor datapath in which every unit talks over one shared 32-bit data bus. It holds 64 words of 32 bits. Entries 0 to 31 are the general registers, entry 32 is the program counter, and the entries above that are spare special-purpose storage. A small selector works out which entry a cycle touches. It can pick a fixed constant (the program counter at 32 or the return-address register at 1), or one of the three 5-bit register-specifier fields of the current instruction word, widened to 6 bits with a zero in the top bit.

Two microcode controls set what happens in a cycle. The file enable gates all activity. The write-mode bit chooses between putting the selected entry onto the bus and taking the bus value into it. A read is combinational, so the output follows the selected address within the same cycle. A write takes effect at the next rising clock edge. The bus is modelled as a separate output word plus an output-enable line, which keeps the block synthesizable. The surrounding bus fabric merges the drivers. Entry 0 is hardwired to zero.

Top module: `bus_regfile`

## Requirements
- R1: While reset is asserted (rst_n low, active low, asynchronous), every entry clears to zero. After reset, any read returns zero until that entry is written.
- R2: Selector code 0 addresses entry 32 (program counter) and selector code 1 addresses entry 1 (return address), whatever the instruction word holds.
- R3: Selector code 2 addresses the entry given by instr[19:15], code 3 uses instr[24:20] and code 4 uses instr[11:7]. Each field is zero-extended to 6 bits.
- R4: With file_en low, bus_oe is low and no entry changes on the clock edge, whatever write_mode and bus_in hold.
- R5: With file_en high and write_mode low, bus_oe is high and bus_out equals the selected entry. A change of addr_sel or instr alters bus_out in the same cycle, without a clock edge, and the read alters no entry.
- R6: With file_en high and write_mode high, bus_in is stored into the selected entry at the next rising edge, and bus_oe stays low during that cycle.
- R7: Entry 0 always reads as zero, and writes aimed at it are discarded.
- R8: Selector codes 5, 6 and 7 address entry 0, so they read zero and their writes change nothing.
- R9: Whenever bus_oe is low, bus_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Current instruction word supplying the specifier fields |
| addr_sel | input | 3 | Address source: 0 PC, 1 RA, 2 rs1, 3 rs2, 4 rd, 5-7 entry 0 |
| file_en | input | 1 | Enables any read or write this cycle |
| write_mode | input | 1 | 1 = capture bus_in, 0 = drive bus_out |
| bus_in | input | 32 | Value present on the shared bus |
| bus_out | output | 32 | Value this block drives onto the bus |
| bus_oe | output | 1 | High when bus_out should be driving the bus |

## Verification
The bench fills each field position of the instruction with a different register number. A selector that takes the wrong bit slice, or pads rs1 with a one, would then read or write the wrong entry, and the mismatch shows up on readback. Idle cycles carry write_mode high and live bus data, so a design that ignores the enable would corrupt a stored word. The bench changes the specifier field with no clock edge in between, which catches a design that registers the read. It also writes entry 0 and the unused selector codes and then reads the program counter and return address back, to catch stray writes.

// File: rtl/bus_regfile_pkg.sv
package bus_regfile_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_PC  = 3'd0,
      SEL_RA  = 3'd1,
      SEL_RS1 = 3'd2,
      SEL_RS2 = 3'd3,
      SEL_RD  = 3'd4
   } regsel_e;
endpackage

// File: rtl/bus_regfile_addr_sel.sv
module bus_regfile_addr_sel
   import bus_regfile_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int ADDR_W  = 6,
   parameter int SPEC_W  = 5,
   parameter int RD_LSB  = 7,
   parameter int RS1_LSB = 15,
   parameter int RS2_LSB = 20,
   parameter int PC_ADDR = 32,
   parameter int RA_ADDR = 1
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [SEL_W-1:0]   sel,
   output logic [ADDR_W-1:0]  addr
);
   localparam int PAD_W = ADDR_W - SPEC_W;

   if (SPEC_W >= ADDR_W) begin : g_bad_spec
      $error("specifier width must be narrower than the address");
   end
   if (RS2_LSB + SPEC_W > INSTR_W || RS1_LSB + SPEC_W > INSTR_W || RD_LSB + SPEC_W > INSTR_W) begin : g_bad_field
      $error("specifier field lies outside the instruction word");
   end
   if (PC_ADDR >= (1 << ADDR_W) || RA_ADDR >= (1 << ADDR_W)) begin : g_bad_const
      $error("fixed register address out of range");
   end

   logic [SPEC_W-1:0] f_rs1, f_rs2, f_rd;
   logic              unused_instr;

   assign f_rs1        = instr[RS1_LSB +: SPEC_W];
   assign f_rs2        = instr[RS2_LSB +: SPEC_W];
   assign f_rd         = instr[RD_LSB  +: SPEC_W];
   assign unused_instr = ^instr;

   always_comb begin
      case (sel)
         SEL_PC:  addr = ADDR_W'(PC_ADDR);
         SEL_RA:  addr = ADDR_W'(RA_ADDR);
         SEL_RS1: addr = {{PAD_W{1'b0}}, f_rs1};
         SEL_RS2: addr = {{PAD_W{1'b0}}, f_rs2};
         SEL_RD:  addr = {{PAD_W{1'b0}}, f_rd};
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/bus_regfile_store.sv
module bus_regfile_store #(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 6,
   parameter bit HARDWIRE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
      $error("address width out of supported range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("data width must be positive");
   end

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (HARDWIRE_ZERO && i == 0) begin : g_zero
         assign cell_q[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = wr_en && (addr == ADDR_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
         assign cell_q[i] = q;
      end
   end

   assign rd_data = cell_q[addr];
endmodule

// File: rtl/bus_regfile_port.sv
module bus_regfile_port #(
   parameter int DATA_W = 32
) (
   input  logic              file_en,
   input  logic              write_mode,
   input  logic [DATA_W-1:0] bus_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   logic drive;

   assign drive   = file_en & ~write_mode;
   assign wr_en   = file_en & write_mode;
   assign wr_data = bus_in;
   assign bus_oe  = drive;
   assign bus_out = drive ? rd_data : '0;
endmodule

// File: rtl/bus_regfile.sv
module bus_regfile
   import bus_regfile_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 6,
   parameter int SPEC_W        = 5,
   parameter int INSTR_W       = 32,
   parameter int RD_LSB        = 7,
   parameter int RS1_LSB       = 15,
   parameter int RS2_LSB       = 20,
   parameter int PC_ADDR       = 32,
   parameter int RA_ADDR       = 1,
   parameter bit HARDWIRE_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [SEL_W-1:0]   addr_sel,
   input  logic               file_en,
   input  logic               write_mode,
   input  logic [DATA_W-1:0]  bus_in,
   output logic [DATA_W-1:0]  bus_out,
   output logic               bus_oe
);
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] wr_data;
   logic              wr_en;

   bus_regfile_addr_sel #(
      .INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .SPEC_W(SPEC_W),
      .RD_LSB(RD_LSB), .RS1_LSB(RS1_LSB), .RS2_LSB(RS2_LSB),
      .PC_ADDR(PC_ADDR), .RA_ADDR(RA_ADDR)
   ) u_sel (
      .instr(instr), .sel(addr_sel), .addr(sel_addr)
   );

   bus_regfile_store #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HARDWIRE_ZERO(HARDWIRE_ZERO)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .addr(sel_addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   bus_regfile_port #(
      .DATA_W(DATA_W)
   ) u_port (
      .file_en(file_en), .write_mode(write_mode), .bus_in(bus_in),
      .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
      .bus_out(bus_out), .bus_oe(bus_oe)
   );
endmodule

// File: rtl/bus_regfile_checker.sv
module bus_regfile_checker #(
   parameter int DATA_W  = 32,
   parameter int INSTR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [INSTR_W-1:0] instr,
   input logic [2:0]         addr_sel,
   input logic               file_en,
   input logic               write_mode,
   input logic [DATA_W-1:0]  bus_in,
   input logic [DATA_W-1:0]  bus_out,
   input logic               bus_oe
);
   // R4, R5, R6: output enable follows the read condition
   assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe == (file_en && !write_mode));

   // R9: idle output is zero
   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> bus_out == '0);

   // R6: a PC write is visible on the following PC read
   assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (file_en && !write_mode && addr_sel == 3'd0 &&
       $past(file_en && write_mode && addr_sel == 3'd0)) |-> bus_out == $past(bus_in));

   // R7: entry 0 reads zero through rs1
   assert_zero_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (file_en && !write_mode && addr_sel == 3'd2 && instr[19:15] == 5'd0) |-> bus_out == '0);

   // R8: spare selector codes read zero
   assert_spare_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (file_en && !write_mode && addr_sel >= 3'd5) |-> bus_out == '0);

   // R5: repeated reads of the same entry are stable
   assert_read_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(file_en && !write_mode) && file_en && !write_mode &&
       $stable(addr_sel) && $stable(instr)) |-> $stable(bus_out));

   logic unused_chk;
   assign unused_chk = ^bus_in;
endmodule

bind bus_regfile bus_regfile_checker #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr(instr), .addr_sel(addr_sel),
   .file_en(file_en), .write_mode(write_mode), .bus_in(bus_in),
   .bus_out(bus_out), .bus_oe(bus_oe)
);

// File: tb/bus_regfile_bench.sv
`timescale 1ns/1ps
module bus_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [2:0]  addr_sel = '0;
   logic        file_en = 1'b0;
   logic        write_mode = 1'b0;
   logic [31:0] bus_in = '0;
   logic [31:0] bus_out;
   logic        bus_oe;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bus_regfile u_bus_regfile (
      .clk(clk), .rst_n(rst_n), .instr(instr), .addr_sel(addr_sel),
      .file_en(file_en), .write_mode(write_mode), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe)
   );

   function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
      return {7'b1010011, rs2, rs1, 3'b110, rd, 7'b0110011};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] s, input logic [31:0] ins, input logic [31:0] d);
      @(negedge clk);
      addr_sel = s; instr = ins; file_en = 1'b1; write_mode = 1'b1; bus_in = d;
      #5 check("R6 oe low while writing", 32'(bus_oe), 32'd0);
      @(negedge clk);
      file_en = 1'b0; write_mode = 1'b0;
   endtask

   task automatic do_read(input string req, input logic [2:0] s, input logic [31:0] ins, input logic [31:0] exp);
      @(negedge clk);
      addr_sel = s; instr = ins; file_en = 1'b1; write_mode = 1'b0;
      #5 check(req, bus_out, exp);
      check({req, " oe"}, 32'(bus_oe), 32'd1);
      @(negedge clk);
      file_en = 1'b0;
   endtask

   task automatic t_reset;
      #5 check("R1 oe in reset", 32'(bus_oe), 32'd0);
      do_read("R1 PC after reset", 3'd0, '0, 32'd0);
      do_read("R1 RA after reset", 3'd1, '0, 32'd0);
      do_read("R1 r17 after reset", 3'd2, mk(5'd0, 5'd17, 5'd0), 32'd0);
   endtask

   task automatic t_fixed;
      do_write(3'd0, mk(5'd3, 5'd4, 5'd5), 32'hC0DE_0100);
      do_write(3'd1, mk(5'd9, 5'd9, 5'd9), 32'h0000_BEEF);
      do_read("R2 PC", 3'd0, mk(5'd1, 5'd1, 5'd1), 32'hC0DE_0100);
      do_read("R2 RA", 3'd1, mk(5'd0, 5'd0, 5'd0), 32'h0000_BEEF);
      do_read("R3 rs1=1 sees RA", 3'd2, mk(5'd0, 5'd1, 5'd0), 32'h0000_BEEF);
   endtask

   task automatic t_fields;
      do_write(3'd4, mk(5'd5, 5'd6, 5'd7), 32'h5555_0005);
      do_write(3'd3, mk(5'd0, 5'd0, 5'd31), 32'h3131_3131);
      do_write(3'd2, mk(5'd0, 5'd12, 5'd0), 32'h1200_0012);
      do_read("R3 rs1 reads rd-written r5", 3'd2, mk(5'd0, 5'd5, 5'd0), 32'h5555_0005);
      do_read("R3 rs2 reads r5", 3'd3, mk(5'd0, 5'd0, 5'd5), 32'h5555_0005);
      do_read("R3 rd reads rs2-written r31", 3'd4, mk(5'd31, 5'd0, 5'd0), 32'h3131_3131);
      do_read("R3 rs2 reads rs1-written r12", 3'd3, mk(5'd0, 5'd0, 5'd12), 32'h1200_0012);
      do_read("R3 r6 untouched", 3'd2, mk(5'd0, 5'd6, 5'd0), 32'd0);
      do_read("R3 r7 untouched", 3'd2, mk(5'd0, 5'd7, 5'd0), 32'd0);
      do_read("R3 PC not hit by zero pad", 3'd0, '0, 32'hC0DE_0100);
   endtask

   task automatic t_idle;
      @(negedge clk);
      addr_sel = 3'd0; instr = '0; file_en = 1'b0; write_mode = 1'b1; bus_in = 32'hDEAD_DEAD;
      #5 check("R4 oe with enable low", 32'(bus_oe), 32'd0);
      check("R9 idle bus_out", bus_out, 32'd0);
      @(negedge clk);
      addr_sel = 3'd4; instr = mk(5'd5, 5'd0, 5'd0);
      @(negedge clk);
      write_mode = 1'b0;
      do_read("R4 PC kept", 3'd0, '0, 32'hC0DE_0100);
      do_read("R4 r5 kept", 3'd4, mk(5'd5, 5'd0, 5'd0), 32'h5555_0005);
   endtask

   task automatic t_comb;
      @(negedge clk);
      addr_sel = 3'd2; instr = mk(5'd0, 5'd5, 5'd0); file_en = 1'b1; write_mode = 1'b0;
      #3 check("R5 comb read r5", bus_out, 32'h5555_0005);
      instr = mk(5'd0, 5'd31, 5'd0);
      #1 check("R5 comb read r31 same cycle", bus_out, 32'h3131_3131);
      addr_sel = 3'd1;
      #1 check("R5 comb read RA same cycle", bus_out, 32'h0000_BEEF);
      @(negedge clk);
      file_en = 1'b0;
      do_read("R5 read left RA intact", 3'd1, '0, 32'h0000_BEEF);
   endtask

   task automatic t_zero;
      do_write(3'd4, mk(5'd0, 5'd0, 5'd0), 32'hFFFF_FFFF);
      do_read("R7 r0 via rs1", 3'd2, mk(5'd0, 5'd0, 5'd0), 32'd0);
      do_read("R7 r0 via rd", 3'd4, mk(5'd0, 5'd0, 5'd0), 32'd0);
   endtask

   task automatic t_spare;
      for (int s = 5; s < 8; s++) begin
         do_write(3'(s), mk(5'd1, 5'd1, 5'd1), 32'hBAD0_0000 + 32'(s));
         do_read("R8 spare code reads zero", 3'(s), mk(5'd1, 5'd1, 5'd1), 32'd0);
      end
      do_read("R8 PC intact", 3'd0, '0, 32'hC0DE_0100);
      do_read("R8 RA intact", 3'd1, '0, 32'h0000_BEEF);
   endtask

   initial begin
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_fixed;
      t_fields;
      t_idle;
      t_comb;
      t_zero;
      t_spare;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule